// File: doc/BRIEF.md
# Line and Pixel Counter Timing Generator

This block produces vertical-rate timing for an image sensor readout from two cascaded counters. A pixel counter moves forward once for every two master clock cycles, because the master clock runs at twice the pixel rate. A line counter moves forward whenever the pixel counter wraps. From the two counts and a frame parity bit, the block decodes which lines are selected for output, where pairs of summed lines begin, and whether the current line lies inside an electronic zoom window.

Software writes line length, frame length, scan mode and zoom bounds over a simple register-write port. Writes land in staging registers only. The staged set is copied into the active set, which drives the counters and decoder, at the single point where the frame wraps back to line zero. A whole frame is therefore always produced with one consistent configuration.

Top module: `lpc_timing_gen`

## Requirements
- R1: A synchronous active-high reset clears both counters, the frame parity bit and the divider phase. It loads staging and active registers with pixel length 16, frame length 8, frame mode, and zoom bounds first=0 and last=0.
- R2: The pixel counter advances on every second clock edge after reset release, starting with the second edge. `pix_adv` is high in exactly the cycles whose closing edge advances it.
- R3: The pixel counter counts 0 up to the active pixel length minus one and then returns to 0. The line counter advances by one only at that wrap and holds otherwise.
- R4: At the last pixel of the last line (active frame length minus one), the advancing edge returns both counters to 0 and toggles `frame_odd`. `frame_end` is high during that advancing cycle only.
- R5: A write with `wr_en` high stores `wr_data` into staging by address: 0 pixel length [11:0], 1 frame length [10:0], 2 scan mode [1:0] (0 frame, 1 field, 2 double speed, 3 zoom), 3 zoom first line [10:0], 4 zoom last line [10:0]. Writes to addresses 5 to 7 have no effect.
- R6: Staged values reach the active set only on the frame-wrap edge of R4. A write issued in the cycle of that edge is not part of it and waits for the following frame wrap.
- R7: A pixel or frame length below 2 is committed as 2.
- R8: In frame mode, `line_sel` is 1 on every line and `pair_first` is 0.
- R9: In field mode, `line_sel` is 1 on every line and `pair_first` is 1 when bit 0 of the line count equals `frame_odd`, so line pairing shifts by one between even and odd frames.
- R10: In double speed mode, `line_sel` is 1 only when bit 0 of the line count equals `frame_odd`, and `pair_first` is 0.
- R11: `zoom_win` is 1 whenever first <= line count <= last in every mode. In zoom mode, `line_sel` equals `zoom_win` and `pair_first` is 0.
- R12: A reset during operation discards staged writes that have not been committed and restarts timing from the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, twice the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 12 | Register write data |
| pix_cnt | output | 12 | Pixel position within the line |
| line_cnt | output | 11 | Line position within the frame |
| pix_adv | output | 1 | High in cycles whose closing edge advances the pixel counter |
| frame_end | output | 1 | High in the cycle whose edge wraps the frame and commits staging |
| frame_odd | output | 1 | Frame parity |
| line_sel | output | 1 | Current line is an output line in the active mode |
| pair_first | output | 1 | Current line starts a summed pair (field mode) |
| zoom_win | output | 1 | Current line lies in the zoom window |

## Verification
The hardest situation to reach is a write landing in exactly the cycle whose edge commits staging. It must miss that commit and wait a full frame. The stimulus shrinks the frame to a few lines, follows the counters with a cycle-accurate reference model until the model predicts the commit edge, and issues the write in that cycle. A second delicate case is a reset that arrives while staged values are pending. The bench writes new lengths, resets before the wrap and then runs a full frame, which must keep the default lengths.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

    localparam int PIX_W  = 12;
    localparam int LINE_W = 11;
    localparam int ADDR_W = 3;
    localparam int DATA_W = PIX_W;
    localparam int MIN_LEN = 2;

    localparam logic [ADDR_W-1:0] A_PIX_LEN    = 3'd0;
    localparam logic [ADDR_W-1:0] A_LINE_LEN   = 3'd1;
    localparam logic [ADDR_W-1:0] A_MODE       = 3'd2;
    localparam logic [ADDR_W-1:0] A_ZOOM_FIRST = 3'd3;
    localparam logic [ADDR_W-1:0] A_ZOOM_LAST  = 3'd4;

    typedef enum logic [1:0] {
        MODE_FRAME = 2'd0,
        MODE_FIELD = 2'd1,
        MODE_X2    = 2'd2,
        MODE_ZOOM  = 2'd3
    } scan_mode_e;

    typedef struct packed {
        logic [PIX_W-1:0]  pix_len;
        logic [LINE_W-1:0] line_len;
        scan_mode_e        mode;
        logic [LINE_W-1:0] zoom_first;
        logic [LINE_W-1:0] zoom_last;
    } tg_cfg_t;

    typedef struct packed {
        logic line_sel;
        logic pair_first;
        logic zoom_win;
    } line_flags_t;

    function automatic logic [PIX_W-1:0] clamp_pix(input logic [PIX_W-1:0] v);
        return (v < PIX_W'(MIN_LEN)) ? PIX_W'(MIN_LEN) : v;
    endfunction

    function automatic logic [LINE_W-1:0] clamp_line(input logic [LINE_W-1:0] v);
        return (v < LINE_W'(MIN_LEN)) ? LINE_W'(MIN_LEN) : v;
    endfunction

    function automatic tg_cfg_t clamp_cfg(input tg_cfg_t c);
        tg_cfg_t r;
        r          = c;
        r.pix_len  = clamp_pix(c.pix_len);
        r.line_len = clamp_line(c.line_len);
        return r;
    endfunction

endpackage

// File: rtl/lpc_cfg_regs.sv
module lpc_cfg_regs
    import lpc_pkg::*;
#(
    parameter logic [PIX_W-1:0]  DEF_PIX_LEN  = 12'd16,
    parameter logic [LINE_W-1:0] DEF_LINE_LEN = 11'd8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              commit,
    output tg_cfg_t           act_cfg
);

    localparam tg_cfg_t CFG_DEFAULT = '{
        pix_len:    DEF_PIX_LEN,
        line_len:   DEF_LINE_LEN,
        mode:       MODE_FRAME,
        zoom_first: '0,
        zoom_last:  '0
    };

    tg_cfg_t stage_q;
    tg_cfg_t act_q;

    // Staging side: written at any time, never read by the counters.
    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= CFG_DEFAULT;
        end else if (wr_en) begin
            case (wr_addr)
                A_PIX_LEN:    stage_q.pix_len    <= wr_data[PIX_W-1:0];
                A_LINE_LEN:   stage_q.line_len   <= wr_data[LINE_W-1:0];
                A_MODE:       stage_q.mode       <= scan_mode_e'(wr_data[1:0]);
                A_ZOOM_FIRST: stage_q.zoom_first <= wr_data[LINE_W-1:0];
                A_ZOOM_LAST:  stage_q.zoom_last  <= wr_data[LINE_W-1:0];
                default:      stage_q            <= stage_q;
            endcase
        end
    end

    // Active side: takes the pre-write staging contents at the frame wrap.
    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= CFG_DEFAULT;
        end else if (commit) begin
            act_q <= clamp_cfg(stage_q);
        end
    end

    assign act_cfg = act_q;

endmodule

// File: rtl/lpc_counters.sv
module lpc_counters
    import lpc_pkg::*;
#(
    parameter int CLK_PER_PIX = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PIX_W-1:0]  pix_len,
    input  logic [LINE_W-1:0] line_len,
    output logic [PIX_W-1:0]  pix_cnt,
    output logic [LINE_W-1:0] line_cnt,
    output logic              pix_adv,
    output logic              frame_end,
    output logic              frame_odd
);

    logic pix_last;
    logic line_last;

    // Clock divider: picks the edge on which the pixel counter moves.
    generate
        if (CLK_PER_PIX <= 1) begin : g_full_rate
            assign pix_adv = 1'b1;
        end else begin : g_div
            localparam int PH_W = $clog2(CLK_PER_PIX);
            localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLK_PER_PIX - 1);
            logic [PH_W-1:0] phase_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    phase_q <= '0;
                end else if (phase_q == PH_LAST) begin
                    phase_q <= '0;
                end else begin
                    phase_q <= phase_q + PH_W'(1);
                end
            end
            assign pix_adv = (phase_q == PH_LAST);
        end
    endgenerate

    assign pix_last  = (pix_cnt  == pix_len  - PIX_W'(1));
    assign line_last = (line_cnt == line_len - LINE_W'(1));
    assign frame_end = pix_adv && pix_last && line_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_cnt <= '0;
        end else if (pix_adv) begin
            pix_cnt <= pix_last ? '0 : pix_cnt + PIX_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_cnt <= '0;
        end else if (pix_adv && pix_last) begin
            line_cnt <= line_last ? '0 : line_cnt + LINE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_odd <= 1'b0;
        end else if (frame_end) begin
            frame_odd <= ~frame_odd;
        end
    end

endmodule

// File: rtl/lpc_line_decode.sv
module lpc_line_decode
    import lpc_pkg::*;
(
    input  scan_mode_e        mode,
    input  logic [LINE_W-1:0] zoom_first,
    input  logic [LINE_W-1:0] zoom_last,
    input  logic [LINE_W-1:0] line_cnt,
    input  logic              frame_odd,
    output line_flags_t       flags
);

    logic in_zoom;
    logic parity_hit;

    assign in_zoom    = (line_cnt >= zoom_first) && (line_cnt <= zoom_last);
    assign parity_hit = (line_cnt[0] == frame_odd);

    always_comb begin
        flags.zoom_win   = in_zoom;
        flags.line_sel   = 1'b1;
        flags.pair_first = 1'b0;
        case (mode)
            MODE_FRAME: begin
                flags.line_sel = 1'b1;
            end
            MODE_FIELD: begin
                flags.line_sel   = 1'b1;
                flags.pair_first = parity_hit;
            end
            MODE_X2: begin
                flags.line_sel = parity_hit;
            end
            MODE_ZOOM: begin
                flags.line_sel = in_zoom;
            end
            default: begin
                flags.line_sel = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/lpc_timing_gen.sv
module lpc_timing_gen
    import lpc_pkg::*;
#(
    parameter logic [PIX_W-1:0]  DEF_PIX_LEN  = 12'd16,
    parameter logic [LINE_W-1:0] DEF_LINE_LEN = 11'd8,
    parameter int                CLK_PER_PIX  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [11:0]       wr_data,
    output logic [11:0]       pix_cnt,
    output logic [10:0]       line_cnt,
    output logic              pix_adv,
    output logic              frame_end,
    output logic              frame_odd,
    output logic              line_sel,
    output logic              pair_first,
    output logic              zoom_win
);

    tg_cfg_t     act_cfg;
    line_flags_t flags;
    logic        commit;

    assign commit = frame_end;

    lpc_cfg_regs #(
        .DEF_PIX_LEN  (DEF_PIX_LEN),
        .DEF_LINE_LEN (DEF_LINE_LEN)
    ) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .commit  (commit),
        .act_cfg (act_cfg)
    );

    lpc_counters #(
        .CLK_PER_PIX (CLK_PER_PIX)
    ) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .pix_len   (act_cfg.pix_len),
        .line_len  (act_cfg.line_len),
        .pix_cnt   (pix_cnt),
        .line_cnt  (line_cnt),
        .pix_adv   (pix_adv),
        .frame_end (frame_end),
        .frame_odd (frame_odd)
    );

    lpc_line_decode u_dec (
        .mode       (act_cfg.mode),
        .zoom_first (act_cfg.zoom_first),
        .zoom_last  (act_cfg.zoom_last),
        .line_cnt   (line_cnt),
        .frame_odd  (frame_odd),
        .flags      (flags)
    );

    assign line_sel   = flags.line_sel;
    assign pair_first = flags.pair_first;
    assign zoom_win   = flags.zoom_win;

endmodule

// File: rtl/lpc_tg_checker.sv
module lpc_tg_checker
    import lpc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [11:0]       pix_cnt,
    input logic [10:0]       line_cnt,
    input logic              pix_adv,
    input logic              frame_end,
    input logic              frame_odd,
    input logic              line_sel,
    input logic              pair_first,
    input logic              zoom_win,
    input scan_mode_e        act_mode,
    input logic [LINE_W-1:0] act_zoom_first,
    input logic [LINE_W-1:0] act_zoom_last,
    input logic [PIX_W-1:0]  act_pix_len,
    input logic [LINE_W-1:0] act_line_len
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (pix_cnt == '0) && (line_cnt == '0) && !frame_odd);

    assert_adv_alternates_R2: assert property (@(posedge clk) disable iff (rst)
        pix_adv |=> !pix_adv);

    assert_pix_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !pix_adv |=> $stable(pix_cnt) && $stable(line_cnt));

    assert_pix_step_R3: assert property (@(posedge clk) disable iff (rst)
        pix_adv |=> (pix_cnt == $past(pix_cnt) + 12'd1) || (pix_cnt == '0));

    assert_line_step_R3: assert property (@(posedge clk) disable iff (rst)
        (pix_adv && pix_cnt != '0) |=> (pix_cnt == '0) || $stable(line_cnt));

    assert_frame_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (pix_cnt == '0) && (line_cnt == '0) && (frame_odd != $past(frame_odd)));

    assert_parity_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(frame_odd));

    assert_cfg_stable_R6: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(act_mode) && $stable(act_pix_len) && $stable(act_line_len));

    assert_len_clamp_R7: assert property (@(posedge clk) disable iff (rst)
        (act_pix_len >= 12'd2) && (act_line_len >= 11'd2));

    assert_pix_range_R3: assert property (@(posedge clk) disable iff (rst)
        (pix_cnt < act_pix_len) && (line_cnt < act_line_len));

    assert_frame_sel_R8: assert property (@(posedge clk) disable iff (rst)
        (act_mode == MODE_FRAME) |-> line_sel && !pair_first);

    assert_x2_sel_R10: assert property (@(posedge clk) disable iff (rst)
        (act_mode == MODE_X2) |-> (line_sel == (line_cnt[0] == frame_odd)) && !pair_first);

    assert_zoom_sel_R11: assert property (@(posedge clk) disable iff (rst)
        zoom_win |-> (line_cnt >= act_zoom_first) && (line_cnt <= act_zoom_last));

endmodule

bind lpc_timing_gen lpc_tg_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .pix_cnt        (pix_cnt),
    .line_cnt       (line_cnt),
    .pix_adv        (pix_adv),
    .frame_end      (frame_end),
    .frame_odd      (frame_odd),
    .line_sel       (line_sel),
    .pair_first     (pair_first),
    .zoom_win       (zoom_win),
    .act_mode       (act_cfg.mode),
    .act_zoom_first (act_cfg.zoom_first),
    .act_zoom_last  (act_cfg.zoom_last),
    .act_pix_len    (act_cfg.pix_len),
    .act_line_len   (act_cfg.line_len)
);

// File: tb/sim_lpc_timing_gen.sv
`timescale 1ns/1ps
module sim_lpc_timing_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic [11:0] pix_cnt;
    logic [10:0] line_cnt;
    logic        pix_adv, frame_end, frame_odd, line_sel, pair_first, zoom_win;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // Reference model state
    int m_ph, m_pix, m_line;
    bit m_odd;
    int s_pl, s_fl, s_md, s_zf, s_zl;
    int a_pl, a_fl, a_md, a_zf, a_zl;
    bit m_fe;

    always #2.5 clk = ~clk;

    lpc_timing_gen u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pix_cnt(pix_cnt), .line_cnt(line_cnt), .pix_adv(pix_adv),
        .frame_end(frame_end), .frame_odd(frame_odd), .line_sel(line_sel),
        .pair_first(pair_first), .zoom_win(zoom_win)
    );

    function automatic int clmp(input int v);
        return (v < 2) ? 2 : v;
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic compare();
        bit e_adv, e_fe, e_zw, e_sel, e_pf;
        e_adv = (m_ph == 1);
        e_fe  = e_adv && (m_pix == a_pl - 1) && (m_line == a_fl - 1);
        e_zw  = (m_line >= a_zf) && (m_line <= a_zl);
        e_sel = 1'b1;
        e_pf  = 1'b0;
        case (a_md)
            1: e_pf = ((m_line % 2) == int'(m_odd));       // field
            2: e_sel = ((m_line % 2) == int'(m_odd));      // double speed
            3: e_sel = e_zw;                               // zoom
            default: ;
        endcase
        m_fe = e_fe;
        checks++;
        if (pix_cnt !== 12'(m_pix) || line_cnt !== 11'(m_line) || pix_adv !== e_adv ||
            frame_end !== e_fe || frame_odd !== m_odd || line_sel !== e_sel ||
            pair_first !== e_pf || zoom_win !== e_zw) begin
            errors++;
            $display("FAIL %s: got pix=%0d line=%0d adv=%b fe=%b odd=%b sel=%b pf=%b zw=%b exp pix=%0d line=%0d adv=%b fe=%b odd=%b sel=%b pf=%b zw=%b",
                     cur_req, pix_cnt, line_cnt, pix_adv, frame_end, frame_odd, line_sel,
                     pair_first, zoom_win, m_pix, m_line, e_adv, e_fe, m_odd, e_sel, e_pf, e_zw);
        end
    endtask

    // One clock: predict next state from current inputs, then compare.
    task automatic cyc();
        int np, nl, nph;
        bit nodd;
        if (rst) begin
            m_ph = 0; m_pix = 0; m_line = 0; m_odd = 0;
            s_pl = 16; s_fl = 8; s_md = 0; s_zf = 0; s_zl = 0;
            a_pl = 16; a_fl = 8; a_md = 0; a_zf = 0; a_zl = 0;
        end else begin
            np = m_pix; nl = m_line; nodd = m_odd;
            if (m_ph == 1) begin
                if (m_pix == a_pl - 1) begin
                    np = 0;
                    if (m_line == a_fl - 1) begin
                        nl = 0;
                        nodd = !m_odd;
                        a_pl = clmp(s_pl); a_fl = clmp(s_fl);
                        a_md = s_md; a_zf = s_zf; a_zl = s_zl;
                    end else begin
                        nl = m_line + 1;
                    end
                end else begin
                    np = m_pix + 1;
                end
            end
            nph = 1 - m_ph;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: s_pl = int'(wr_data);
                    3'd1: s_fl = int'(wr_data[10:0]);
                    3'd2: s_md = int'(wr_data[1:0]);
                    3'd3: s_zf = int'(wr_data[10:0]);
                    3'd4: s_zl = int'(wr_data[10:0]);
                    default: ;
                endcase
            end
            m_pix = np; m_line = nl; m_odd = nodd; m_ph = nph;
        end
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        compare();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(input logic [2:0] a, input logic [11:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc();
    endtask

    task automatic to_commit();
        while (!m_fe) cyc();
        cyc();
    endtask

    task automatic pulse_reset();
        rst = 1'b1;
        cyc();
        rst = 1'b0;
    endtask

    // R1: reset values
    task automatic t_reset();
        cur_req = "R1";
        pulse_reset();
        pulse_reset();
    endtask

    // R2: half-rate advance
    task automatic t_rate();
        cur_req = "R2";
        run(10);
    endtask

    // R3, R4: full default frame and parity toggle
    task automatic t_default_frame();
        cur_req = "R3";
        run(100);
        cur_req = "R4";
        to_commit();
        run(4);
    endtask

    // R5, R6: staged writes wait for the frame wrap
    task automatic t_staging();
        cur_req = "R6";
        wr(3'd0, 12'd5);
        wr(3'd1, 12'd3);
        run(30);
        cur_req = "R5";
        to_commit();
        run(70);
    endtask

    // R6: write in the commit cycle waits a frame
    task automatic t_commit_edge();
        cur_req = "R6";
        while (!m_fe) cyc();
        wr(3'd0, 12'd3);
        run(40);
        to_commit();
        run(30);
    endtask

    // R7: lengths below 2
    task automatic t_clamp();
        cur_req = "R7";
        wr(3'd0, 12'd0);
        wr(3'd1, 12'd1);
        to_commit();
        run(24);
        wr(3'd0, 12'd1);
        wr(3'd1, 12'd0);
        to_commit();
        run(12);
    endtask

    // R8, R9, R10: line selection by mode across both parities
    task automatic t_modes();
        wr(3'd0, 12'd3);
        wr(3'd1, 12'd5);
        cur_req = "R8";
        wr(3'd2, 12'd0);
        to_commit();
        run(60);
        cur_req = "R9";
        wr(3'd2, 12'd1);
        to_commit();
        run(65);
        cur_req = "R10";
        wr(3'd2, 12'd2);
        to_commit();
        run(65);
    endtask

    // R11: zoom window and zoom mode
    task automatic t_zoom();
        cur_req = "R11";
        wr(3'd1, 12'd7);
        wr(3'd3, 12'd2);
        wr(3'd4, 12'd4);
        to_commit();
        run(50);
        wr(3'd2, 12'd3);
        to_commit();
        run(50);
        wr(3'd3, 12'd5);
        wr(3'd4, 12'd1);
        to_commit();
        run(45);
    endtask

    // R5: unused addresses leave every setting unchanged
    task automatic t_bad_addr();
        cur_req = "R5";
        wr(3'd5, 12'd2);
        wr(3'd6, 12'd9);
        wr(3'd7, 12'd0);
        to_commit();
        run(50);
    endtask

    // R12: reset drops pending staged values
    task automatic t_mid_reset();
        cur_req = "R12";
        wr(3'd0, 12'd4);
        wr(3'd2, 12'd2);
        run(5);
        pulse_reset();
        to_commit();
        run(40);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete (got timeout, expected finish)");
        summary();
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_rate();
        t_default_frame();
        t_staging();
        t_commit_edge();
        t_clamp();
        t_modes();
        t_zoom();
        t_bad_addr();
        t_mid_reset();
        summary();
        $finish;
    end

endmodule